// File: doc/BRIEF.md
# Interrupt Countdown Timer

This block is a programmable down-counter that raises an interrupt vector toward a local interrupt controller when its count runs out. Software programs a divider that slows a base tick enable, an initial count that loads and restarts the counter, and a timer entry that holds an 8-bit vector, a mask flag and a one-shot/periodic select. The live count can be read back at any time.

In one-shot mode the counter runs down once and rests at zero. In periodic mode it passes through zero and reloads itself from the initial count, so a load value of V gives an interrupt every V+1 divided ticks. An initial count of zero keeps the timer idle. On the divided tick that takes the count from one to zero, an unmasked entry produces a one-cycle strobe that carries the vector.

Top module: `irq_timer_top`

## Requirements
- R1: Register select `regAddr` is 0 for the divider, 1 for the initial count, 2 for the current count and 3 for the timer entry. A write to the divider keeps only bits 0, 1 and 3, so writing 0xF reads back 0xB.
- R2: The divider index is {bit3, bit1, bit0}. The count advances once every 2^((index+1) mod 8) base ticks, so index 7 (value 0xB) divides by 1 and value 0xA divides by 128. The first decrement after a load comes N base ticks after the load, where N is the divisor.
- R3: Writing the initial count loads both the initial and the current count and restarts the divider phase. A load that falls on the same cycle as a divided tick takes priority, and that tick neither decrements nor delivers.
- R4: In one-shot mode (entry bit 17 = 0) the count drops by one on each divided tick and stays at zero. This gives exactly one delivery per load, N*V base ticks after loading V.
- R5: In periodic mode (entry bit 17 = 1) a divided tick at count zero reloads the initial count. Deliveries repeat every V+1 divided ticks.
- R6: Entry bit 16 masks delivery. When it is clear, the tick that takes the count from 1 to 0 produces `vecValid` high for exactly one cycle, with `vecNum` equal to entry bits 7:0, in the same cycle the count first reads zero.
- R7: The current-count register is read-only, and a write to it changes neither the count nor any other register.
- R8: Writing the timer entry takes effect on the next divided tick. Switching an expired one-shot timer to periodic reloads it at the next tick, giving a delivery V+1 divided ticks after the entry write.
- R9: An initial count of zero disarms the timer. It then delivers nothing in either mode, and the current count reads zero.
- R10: After reset the divider, initial count and current count read 0, the timer entry reads 0x00010000 (masked), and `vecValid` is low.
- R11: The count moves only on cycles where `tickIn` is high. With `tickIn` held low the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Base tick enable, one count source pulse per high cycle |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 divider, 1 initial, 2 current, 3 entry) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr`, combinational |
| vecValid | output | 1 | One-cycle interrupt delivery strobe |
| vecNum | output | 8 | Vector delivered with `vecValid` |

## Verification
A software reload of the initial count and the divided tick that would take the count to zero can land in the same cycle. When they do, the load must win and the expiry must be dropped. The bench provokes this by loading a count of 2 at divide-by-1, letting one tick pass, and timing a second load onto exactly the edge of the expiring tick. It then requires that no strobe appears on that edge and that the next strobe arrives exactly as many ticks after the second load as the new count.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned DIV_IDX_W   = 3;
  localparam int unsigned PRE_W       = (1 << DIV_IDX_W) - 1;
  localparam int unsigned ENTRY_MASK  = 16;
  localparam int unsigned ENTRY_MODE  = 17;
  localparam logic [3:0]  DIV_KEEP    = 4'hB;

  typedef enum logic [1:0] {
    SEL_DIV   = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_ENTRY = 2'd3
  } regSel_e;

  // strobes and settings passed from control to datapath
  typedef struct packed {
    logic             loadInit;
    logic             divTick;
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } timerCmd_t;
endpackage

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  initVal,
  input  logic [CNT_W-1:0]  curVal,
  output logic [DATA_W-1:0] rdData,
  output timerCmd_t         cmd
);
  logic [3:0]           divReg;
  logic                 entryMasked;
  logic                 entryPeriodic;
  logic [VEC_W-1:0]     entryVec;
  logic [PRE_W-1:0]     preCnt;
  logic [DIV_IDX_W-1:0] divIdx;
  logic [DIV_IDX_W-1:0] shiftAmt;
  logic [PRE_W:0]       maskWide;
  logic [PRE_W-1:0]     preMask;
  logic                 wrDiv, wrInit, wrEntry;

  assign wrDiv   = wrEn && (regAddr == SEL_DIV);
  assign wrInit  = wrEn && (regAddr == SEL_INIT);
  assign wrEntry = wrEn && (regAddr == SEL_ENTRY);

  // divider index from the scattered bits, shift wraps modulo 8
  assign divIdx   = {divReg[3], divReg[1:0]};
  assign shiftAmt = divIdx + DIV_IDX_W'(1);
  assign maskWide = ((PRE_W+1)'(1) << shiftAmt) - (PRE_W+1)'(1);
  assign preMask  = maskWide[PRE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg        <= '0;
      entryMasked   <= 1'b1;
      entryPeriodic <= 1'b0;
      entryVec      <= '0;
    end else begin
      if (wrDiv) divReg <= wrData[3:0] & DIV_KEEP;
      if (wrEntry) begin
        entryVec      <= wrData[VEC_W-1:0];
        entryMasked   <= wrData[ENTRY_MASK];
        entryPeriodic <= wrData[ENTRY_MODE];
      end
    end
  end

  // prescaler phase restarts with every initial-count load
  always_ff @(posedge clk) begin
    if (!rstN)       preCnt <= '0;
    else if (wrInit) preCnt <= '0;
    else if (tickIn) preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    cmd          = '0;
    cmd.loadInit = wrInit;
    cmd.divTick  = tickIn && ((preCnt & preMask) == preMask);
    cmd.periodic = entryPeriodic;
    cmd.masked   = entryMasked;
    cmd.vector   = entryVec;
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      SEL_DIV:   rdData[3:0] = divReg;
      SEL_INIT:  rdData[CNT_W-1:0] = initVal;
      SEL_CUR:   rdData[CNT_W-1:0] = curVal;
      SEL_ENTRY: begin
        rdData[VEC_W-1:0]  = entryVec;
        rdData[ENTRY_MASK] = entryMasked;
        rdData[ENTRY_MODE] = entryPeriodic;
      end
      default:   rdData = '0;
    endcase
  end

  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.divTick |-> tickIn);

  // R1
  div_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDiv |=> (divReg[2] == 1'b0));
endmodule

// File: rtl/irq_timer_dp.sv
module irq_timer_dp
  import irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCmd_t        cmd,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] curVal,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecNum
);
  logic [CNT_W-1:0] initReg;
  logic [CNT_W-1:0] curReg;
  logic             armed;
  logic             atZero;
  logic             atOne;

  assign atZero = (curReg == '0);
  assign atOne  = (curReg == CNT_W'(1));
  // arming is re-derived every cycle from the current entry mode
  assign armed  = (initReg != '0) && (cmd.periodic || !atZero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReg  <= '0;
      curReg   <= '0;
      vecValid <= 1'b0;
      vecNum   <= '0;
    end else begin
      vecValid <= 1'b0;
      if (cmd.loadInit) begin
        initReg <= loadVal;
        curReg  <= loadVal;
      end else if (cmd.divTick && armed) begin
        if (atZero) begin
          curReg <= initReg;
        end else begin
          curReg <= curReg - CNT_W'(1);
          if (atOne && !cmd.masked) begin
            vecValid <= 1'b1;
            vecNum   <= cmd.vector;
          end
        end
      end
    end
  end

  assign initVal = initReg;
  assign curVal  = curReg;

  // R4
  oneshot_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.loadInit && !cmd.periodic) |=> (curReg <= $past(curReg)));

  // R6
  strobe_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> atZero);

  // R6
  strobe_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(!cmd.masked));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  // R11
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.divTick && !cmd.loadInit) |=> $stable(curReg));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initReg == '0) |-> !vecValid);
endmodule

// File: rtl/irq_timer_top.sv
module irq_timer_top
  import irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecNum
);
  timerCmd_t        cmd;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] curVal;

  irq_timer_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .initVal (initVal),
    .curVal  (curVal),
    .rdData  (rdData),
    .cmd     (cmd)
  );

  irq_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .loadVal  (wrData[CNT_W-1:0]),
    .initVal  (initVal),
    .curVal   (curVal),
    .vecValid (vecValid),
    .vecNum   (vecNum)
  );
endmodule

// File: tb/tb_irq_timer_top.sv
module tb_irq_timer_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        vecValid;
  logic [7:0]  vecNum;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  localparam logic [1:0] A_DIV = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_ENT = 2'd3;
  localparam logic [31:0] MASKB = 32'h0001_0000, PERB = 32'h0002_0000;

  irq_timer_top dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .vecValid(vecValid), .vecNum(vecNum)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  // counts edges until a strobe; -1 if none within limit
  task automatic waitStrobe(input int limit, output int edges, output logic [7:0] v);
    int n = 0;
    edges = -1; v = '0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (vecValid) begin edges = n; v = vecNum; break; end
    end
  endtask

  task automatic disarm();
    wr(A_INIT, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(A_DIV, d);  check("R10 divider", d, 32'h0);
    rd(A_INIT, d); check("R10 initial", d, 32'h0);
    rd(A_CUR, d);  check("R10 current", d, 32'h0);
    rd(A_ENT, d);  check("R10 entry", d, 32'h0001_0000);
    check("R10 strobe", {31'b0, vecValid}, 32'h0);
  endtask

  task automatic testDivMask();
    logic [31:0] d;
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, d); check("R1 divider keep", d, 32'hB);
  endtask

  task automatic runDivide(input logic [31:0] div, input int v, input int n, input logic [7:0] vec);
    int e; logic [7:0] got; logic [31:0] d;
    wr(A_DIV, div);
    wr(A_ENT, {24'b0, vec});
    tickIn = 1'b1;
    wr(A_INIT, v);
    waitStrobe(n * v + 20, e, got);
    check("R2 expiry ticks", e, n * v);
    check("R6 vector", {24'b0, got}, {24'b0, vec});
    waitStrobe(60, e, got);
    check("R4 one-shot no repeat", e, -1);
    rd(A_CUR, d); check("R4 rests at zero", d, 32'h0);
    disarm();
  endtask

  task automatic testPeriodic();
    int e; logic [7:0] got;
    wr(A_DIV, 32'hB);
    wr(A_ENT, PERB | 32'h5A);
    tickIn = 1'b1;
    wr(A_INIT, 32'd3);
    waitStrobe(20, e, got); check("R5 first expiry", e, 3);
    waitStrobe(20, e, got); check("R5 period V+1", e, 4);
    waitStrobe(20, e, got); check("R5 period again", e, 4);
    check("R6 periodic vector", {24'b0, got}, 32'h5A);
    disarm();
  endtask

  task automatic testMasked();
    int e; logic [7:0] got; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, MASKB | 32'h55);
    tickIn = 1'b1;
    wr(A_INIT, 32'd3);
    waitStrobe(20, e, got); check("R6 masked no strobe", e, -1);
    rd(A_CUR, d); check("R6 masked count ran", d, 32'h0);
    disarm();
  endtask

  task automatic testCurWrite();
    logic [31:0] d;
    tickIn = 1'b0;
    wr(A_DIV, 32'hB);
    wr(A_ENT, MASKB);
    wr(A_INIT, 32'd100);
    wr(A_CUR, 32'd5);
    rd(A_CUR, d);  check("R7 current write ignored", d, 32'd100);
    rd(A_INIT, d); check("R7 initial untouched", d, 32'd100);
    repeat (10) @(negedge clk);
    rd(A_CUR, d); check("R11 holds without tick", d, 32'd100);
    tickIn = 1'b1;
    repeat (3) @(negedge clk);
    tickIn = 1'b0;
    rd(A_CUR, d); check("R11 three ticks", d, 32'd97);
    tickIn = 1'b1;
    disarm();
  endtask

  task automatic testZeroInit();
    int e; logic [7:0] got; logic [31:0] d;
    wr(A_DIV, 32'hB);
    wr(A_ENT, PERB | 32'h11);
    tickIn = 1'b1;
    wr(A_INIT, 32'd0);
    waitStrobe(30, e, got); check("R9 zero count idle", e, -1);
    rd(A_CUR, d); check("R9 current zero", d, 32'h0);
  endtask

  task automatic testRearm();
    int e; logic [7:0] got;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h33);
    tickIn = 1'b1;
    wr(A_INIT, 32'd4);
    waitStrobe(20, e, got); check("R4 one-shot expiry", e, 4);
    repeat (5) @(negedge clk);
    wr(A_ENT, PERB | 32'h33);
    waitStrobe(20, e, got); check("R8 entry write rearms", e, 5);
    disarm();
  endtask

  task automatic testRestart();
    int e; logic [7:0] got;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h44);
    tickIn = 1'b1;
    wr(A_INIT, 32'd10);
    repeat (4) @(negedge clk);
    wr(A_INIT, 32'd3);
    waitStrobe(20, e, got); check("R3 reload restarts", e, 3);
    disarm();
  endtask

  task automatic testCollide();
    int e; logic [7:0] got;
    wr(A_DIV, 32'hB);
    wr(A_ENT, 32'h21);
    tickIn = 1'b1;
    wr(A_INIT, 32'd2);
    @(negedge clk);
    wr(A_INIT, 32'd4);
    check("R3 load beats expiring tick", {31'b0, vecValid}, 32'h0);
    waitStrobe(20, e, got); check("R3 expiry after collision", e, 4);
    disarm();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDivMask();
    runDivide(32'h0, 3, 2, 8'h42);
    runDivide(32'hB, 5, 1, 8'h43);
    runDivide(32'h3, 2, 16, 8'h44);
    runDivide(32'h8, 2, 32, 8'h45);
    runDivide(32'hA, 1, 128, 8'h46);
    testPeriodic();
    testMasked();
    testCurWrite();
    testZeroInit();
    testRearm();
    testRestart();
    testCollide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule